// File: doc/BRIEF.md
# Additive Signed Byte-Credit Counter

This block holds the number of bytes a DMA stream is still allowed to request. Software never loads the count directly. It posts signed byte deltas, and each delta is added to the count. In parallel, the datapath asks for a request size every cycle. The block answers with a grant that never exceeds the remaining credit, and charges that grant against the count. A delta and a charge in the same cycle are merged into one exact update.

If a posted delta would drive the count below zero, the delta is dropped and a status bit records the rejection. That bit is rewritten on every delta, so it always describes the most recent one. A clear strobe is the only way to reach a known count. Enable and disable strobes choose between two modes. In credit-limited mode, grants are trimmed to the remaining credit. In unlimited mode, grants equal the request and the count is not charged.

Top module: `credit_counter`

## Requirements
- R1: After reset the counter is disabled, the rejection flag reads 0, `available_o` reads all ones and `grant_o` equals `req_bytes_i` whenever `req_valid_i` is 1.
- R2: A cycle with `clear_i` high sets the count to 0 plus any delta posted in that same cycle. When enabled, that cycle grants 0 and charges nothing.
- R3: `enable_i` turns credit-limited mode on and `disable_i` turns it off, effective the next cycle. When both are high in the same cycle, the block ends up disabled.
- R4: An accepted delta is added to the count as a two's-complement signed value of `CW` bits, visible on `count_o` the next cycle.
- R5: A delta whose merged result is below zero leaves the count as if no delta were posted and sets `ignored_o` to 1. A non-negative result sets it to 0. The flag holds its value in cycles without a delta.
- R6: When enabled and `req_valid_i` is 1, `grant_o` is the smaller of `req_bytes_i` and the count. The count drops by exactly that grant the next cycle, so repeated requests run the count to exactly 0.
- R7: A delta and a charge in the same cycle both apply. The sign test is made on count minus grant plus delta.
- R8: When enabled and the count is 0, `paused_o` is 1 and `grant_o` is 0.
- R9: When disabled, `grant_o` equals `req_bytes_i`, the count is not charged and `available_o` is all ones. Deltas still apply.
- R10: When enabled, `available_o` equals the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of mode and flag |
| clear_i | input | 1 | Strobe: zero the count |
| enable_i | input | 1 | Strobe: enter credit-limited mode |
| disable_i | input | 1 | Strobe: enter unlimited mode |
| wr_valid_i | input | 1 | A signed delta is posted this cycle |
| wr_delta_i | input | CW | Signed byte delta |
| req_valid_i | input | 1 | A request is being sized this cycle |
| req_bytes_i | input | RW | Requested byte count |
| grant_o | output | RW | Bytes granted this cycle |
| count_o | output | CW | Current credit |
| available_o | output | CW | Credit, or all ones when unlimited |
| enabled_o | output | 1 | Credit-limited mode active |
| ignored_o | output | 1 | Last delta was rejected |
| paused_o | output | 1 | Enabled with zero credit |

## Verification
A wrong count shows on `count_o` and `available_o` one cycle after the update that corrupted it. In the same cycle it also shows as an over- or under-sized `grant_o` for any request larger than the credit. A mis-merged delta and charge differs from the bench's arithmetic by exactly the grant or the delta, so sweeping credit, delta and request together exposes it on the next cycle. A wrong sign decision flips `ignored_o` and leaves the count off by the delta, both visible one cycle after the write.

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int CW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          enable_i,
  input  logic          disable_i,
  input  logic          wr_valid_i,
  input  logic [CW-1:0] wr_delta_i,
  input  logic          req_valid_i,
  input  logic [RW-1:0] req_bytes_i,
  output logic [RW-1:0] grant_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] available_o,
  output logic          enabled_o,
  output logic          ignored_o,
  output logic          paused_o
);
  localparam int EW = CW + 2;

  logic [CW-1:0] count_q;
  logic          en_q;
  logic          ign_q;

  logic [CW-1:0] req_ext;
  logic          short_credit;
  logic [RW-1:0] grant;
  logic [EW-1:0] base_ext, charge_ext, delta_ext, kept_ext, sum_ext;
  logic          reject;
  logic [CW-1:0] count_d;

  assign req_ext      = {{(CW-RW){1'b0}}, req_bytes_i};
  assign short_credit = count_q < req_ext;

  always_comb begin
    if (!req_valid_i)       grant = '0;
    else if (!en_q)         grant = req_bytes_i;
    else if (clear_i)       grant = '0;
    else if (short_credit)  grant = count_q[RW-1:0];
    else                    grant = req_bytes_i;
  end

  assign base_ext   = clear_i ? '0 : {2'b00, count_q};
  assign charge_ext = (en_q && !clear_i) ? {{(EW-RW){1'b0}}, grant} : '0;
  assign delta_ext  = {{2{wr_delta_i[CW-1]}}, wr_delta_i};
  assign kept_ext   = base_ext - charge_ext;
  assign sum_ext    = kept_ext + delta_ext;
  assign reject     = sum_ext[EW-1];
  assign count_d    = (wr_valid_i && !reject) ? sum_ext[CW-1:0] : kept_ext[CW-1:0];

  always_ff @(posedge clk) count_q <= count_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ign_q <= 1'b0;
    end else begin
      if (disable_i)      en_q <= 1'b0;
      else if (enable_i)  en_q <= 1'b1;
      if (wr_valid_i)     ign_q <= reject;
    end
  end

  assign grant_o     = grant;
  assign count_o     = count_q;
  assign available_o = en_q ? count_q : '1;
  assign enabled_o   = en_q;
  assign ignored_o   = ign_q;
  assign paused_o    = en_q && (count_q == '0);
endmodule

module credit_counter_props #(
  parameter int CW = 32,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_i,
  input logic          enable_i,
  input logic          disable_i,
  input logic          wr_valid_i,
  input logic          req_valid_i,
  input logic [RW-1:0] req_bytes_i,
  input logic [RW-1:0] grant_o,
  input logic [CW-1:0] count_o,
  input logic          enabled_o,
  input logic          ignored_o
);
  logic known_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       known_q <= 1'b0;
    else if (clear_i) known_q <= 1'b1;
  end

  assert_grant_within_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (known_q && enabled_o) |-> ({{(CW-RW){1'b0}}, grant_o} <= count_o));

  assert_zero_credit_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (known_q && enabled_o && count_o == '0) |-> (grant_o == '0));

  assert_unlimited_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled_o && req_valid_i) |-> (grant_o == req_bytes_i));

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_i |=> $stable(ignored_o));

  assert_reject_never_adds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (known_q && $rose(ignored_o) && !$past(clear_i)) |-> (count_o <= $past(count_o)));

  assert_disable_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> !enabled_o);

  assert_enable_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !disable_i) |=> enabled_o);
endmodule

bind credit_counter credit_counter_props #(.CW(CW), .RW(RW)) u_props (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .enable_i(enable_i),
  .disable_i(disable_i), .wr_valid_i(wr_valid_i), .req_valid_i(req_valid_i),
  .req_bytes_i(req_bytes_i), .grant_o(grant_o), .count_o(count_o),
  .enabled_o(enabled_o), .ignored_o(ignored_o)
);

// File: tb/credit_counter_bench.sv
module credit_counter_bench;
  localparam int CW = 8;
  localparam int RW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic clear_i = 0, enable_i = 0, disable_i = 0;
  logic wr_valid_i = 0;
  logic [CW-1:0] wr_delta_i = '0;
  logic req_valid_i = 0;
  logic [RW-1:0] req_bytes_i = '0;
  logic [RW-1:0] grant_o;
  logic [CW-1:0] count_o, available_o;
  logic enabled_o, ignored_o, paused_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  credit_counter #(.CW(CW), .RW(RW)) u_credit_counter (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .enable_i(enable_i),
    .disable_i(disable_i), .wr_valid_i(wr_valid_i), .wr_delta_i(wr_delta_i),
    .req_valid_i(req_valid_i), .req_bytes_i(req_bytes_i), .grant_o(grant_o),
    .count_o(count_o), .available_o(available_o), .enabled_o(enabled_o),
    .ignored_o(ignored_o), .paused_o(paused_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int c);
    @(negedge clk);
    clear_i = 1; wr_valid_i = 1; wr_delta_i = c[CW-1:0]; req_valid_i = 0;
    @(negedge clk);
    clear_i = 0; wr_valid_i = 0;
  endtask

  task automatic set_mode(input bit e);
    @(negedge clk);
    enable_i = e; disable_i = !e;
    @(negedge clk);
    enable_i = 0; disable_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req_valid_i = 1; req_bytes_i = 4'd9;
    #1;
    chk("R1 enabled", enabled_o, 0);
    chk("R1 ignored", ignored_o, 0);
    chk("R1 available", available_o, 255);
    chk("R1 grant", grant_o, 9);
    req_valid_i = 0;

    // R3: both strobes together leave the block disabled
    set_mode(1);
    chk("R3 enable", enabled_o, 1);
    @(negedge clk); enable_i = 1; disable_i = 1;
    @(negedge clk); enable_i = 0; disable_i = 0;
    chk("R3 both strobes", enabled_o, 0);
    set_mode(1);

    // R2: clear merges with same-cycle delta, charges nothing
    load(30);
    @(negedge clk);
    clear_i = 1; wr_valid_i = 1; wr_delta_i = 8'd9; req_valid_i = 1; req_bytes_i = 4'd3;
    #1 chk("R2 grant in clear", grant_o, 0);
    @(negedge clk); clear_i = 0; wr_valid_i = 0; req_valid_i = 0;
    chk("R2 clear+delta", count_o, 9);
    @(negedge clk);
    clear_i = 1; wr_valid_i = 1; wr_delta_i = 8'hFB;
    @(negedge clk); clear_i = 0; wr_valid_i = 0;
    chk("R2 clear+neg", count_o, 0);
    chk("R2 clear+neg flag", ignored_o, 1);
    @(negedge clk);
    chk("R5 flag holds", ignored_o, 1);

    // R8: zero credit pauses
    req_valid_i = 1; req_bytes_i = 4'd7;
    #1 chk("R8 grant at zero", grant_o, 0);
    chk("R8 paused", paused_o, 1);
    req_valid_i = 0;

    // R6: drain runs exactly to zero
    load(13);
    begin
      int rem = 13;
      for (int k = 0; k < 5; k++) begin
        int g;
        @(negedge clk);
        req_valid_i = 1; req_bytes_i = 4'd4;
        g = (rem < 4) ? rem : 4;
        #1 chk("R6 drain grant", grant_o, g);
        @(negedge clk); req_valid_i = 0;
        rem -= g;
        chk("R6 drain count", count_o, rem);
      end
    end
    chk("R8 paused after drain", paused_o, 1);

    // Enabled sweep: R4 R5 R6 R7 R10
    for (int c = 0; c <= 40; c += 4)
      for (int d = -30; d <= 30; d += 6)
        for (int r = 0; r <= 15; r += 5) begin
          int g, s, nc, nf;
          load(c);
          @(negedge clk);
          wr_valid_i = 1; wr_delta_i = d[CW-1:0]; req_valid_i = 1; req_bytes_i = r[RW-1:0];
          g = (r < c) ? r : c;
          s = c - g + d;
          nc = (s < 0) ? c - g : s;
          nf = (s < 0) ? 1 : 0;
          #1 chk("R6 grant", grant_o, g);
          @(negedge clk); wr_valid_i = 0; req_valid_i = 0;
          if (g == 0) chk("R4 count", count_o, nc);
          else        chk("R7 merged count", count_o, nc);
          chk("R5 flag", ignored_o, nf);
          chk("R10 available", available_o, nc);
        end

    // Disabled sweep: R9
    set_mode(0);
    for (int c = 0; c <= 40; c += 8)
      for (int d = -20; d <= 20; d += 10)
        for (int r = 0; r <= 15; r += 3) begin
          int s, nc;
          load(c);
          @(negedge clk);
          wr_valid_i = 1; wr_delta_i = d[CW-1:0]; req_valid_i = 1; req_bytes_i = r[RW-1:0];
          s = c + d;
          nc = (s < 0) ? c : s;
          #1 chk("R9 grant", grant_o, r);
          chk("R9 available", available_o, 255);
          @(negedge clk); wr_valid_i = 0; req_valid_i = 0;
          chk("R9 count", count_o, nc);
          chk("R5 flag unlimited", ignored_o, (s < 0) ? 1 : 0);
        end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule